// File: doc/BRIEF.md
# Register-Triggered 2D Drawing Engine

This block sits between a processor's register write bus and a single-port frame-buffer memory. Software loads parameter registers for one of four commands: line, rectangle fill, single-pixel plot, and single-pixel read. Writing a command's final coordinate register launches that command.

While a command runs, the engine owns the frame-buffer port and drives `ready` low so the processor waits. Pixels are addressed linearly as `y * SCR_W + x`. The frame buffer has one cycle of read latency: data appears on `fb_rdata` on the clock after a cycle in which `fb_re` is high. Line and fill commands write one pixel per clock until they finish. A read command leaves the fetched 5-6-5 colour on `rd_color`.

Top module: `gfx_engine`

## Requirements
- R1: After reset, `ready` is 1, `fb_we` and `fb_re` are 0, and `rd_color` is 0.
- R2: Register 0 holds the 16-bit 5-6-5 drawing colour. Every pixel that the line, fill and plot commands write carries that value on `fb_wdata`.
- R3: Registers 1, 2 and 3 hold the line start X, start Y and end X. A write to register 4 (end Y) starts the line.
  - Let dx = |x1−x0| and dy = |y1−y0|. The step signs follow the direction to the end point. The error term starts at dx−dy.
  - Each pixel is written, then e2 = 2·err is formed. If e2 ≥ −dy, X steps and err −= dy. If e2 ≤ dx, Y steps and err += dx.
  - Both end points are written, in every octant.
- R4: Registers 5, 6 and 7 hold the fill width minus one, height minus one and X start. A write to register 8 (Y start) fills the rectangle row by row. Every pixel in the rectangle is written.
- R5: Register 9 holds the plot X. A write to register 10 (plot Y) writes exactly one pixel in the current colour.
- R6: Register 11 holds the read X. A write to register 12 (read Y) reads that pixel. Once `ready` returns to 1, `rd_color` holds the stored value.
- R7: `ready` goes low on the clock edge that accepts a launching write and stays low until the command finishes. The frame-buffer port is never used while `ready` is 1.
- R8: While `ready` is 0, all register writes are ignored, including launching writes. The parameter registers keep their old values.
- R9: The frame-buffer address of pixel (x, y) is y·SCR_W + x.
- R10: One pixel is written per clock. The number of busy cycles is:
  - max(dx, dy)+1 for a line;
  - (width)·(height) for a fill;
  - 1 for a plot;
  - 2 for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select (0..12) |
| reg_wdata | input | 16 | Register write data |
| ready | output | 1 | High when the engine is idle and accepting writes |
| rd_color | output | 16 | Colour fetched by the last read command |
| fb_we | output | 1 | Frame-buffer write enable |
| fb_re | output | 1 | Frame-buffer read enable |
| fb_addr | output | AW | Frame-buffer pixel address |
| fb_wdata | output | 16 | Frame-buffer write data |
| fb_rdata | input | 16 | Frame-buffer read data, one cycle after `fb_re` |

## Verification
The hardest situation to reach is a write that arrives while a command is still running. From the processor side it only looks possible if the processor ignores `ready`. The bench therefore launches a multi-row fill and, on the very next cycles, writes a new colour, a start point and a line trigger.

It then plots a pixel after the fill completes. That pixel must carry the old colour, and the frame buffer must show no trace of the rejected line. Lines toward all eight octants, a zero-length line and the far screen corner cover the remaining edges of the stepping and addressing logic.

// File: rtl/gfx_pkg.sv
package gfx_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_LINE   = 3'd1,
        S_FILL   = 3'd2,
        S_PLOT   = 3'd3,
        S_RDREQ  = 3'd4,
        S_RDWAIT = 3'd5
    } state_e;

    localparam logic [3:0] A_COLOR = 4'd0;
    localparam logic [3:0] A_LX0   = 4'd1;
    localparam logic [3:0] A_LY0   = 4'd2;
    localparam logic [3:0] A_LX1   = 4'd3;
    localparam logic [3:0] A_LY1   = 4'd4;
    localparam logic [3:0] A_FLX   = 4'd5;
    localparam logic [3:0] A_FLY   = 4'd6;
    localparam logic [3:0] A_FX    = 4'd7;
    localparam logic [3:0] A_FY    = 4'd8;
    localparam logic [3:0] A_PX    = 4'd9;
    localparam logic [3:0] A_PY    = 4'd10;
    localparam logic [3:0] A_RX    = 4'd11;
    localparam logic [3:0] A_RY    = 4'd12;
endpackage

// File: rtl/gfx_line_step.sv
module gfx_line_step #(
    parameter int XW = 11,
    parameter int YW = 11,
    parameter int EW = 14
) (
    input  logic [XW-1:0]        cx,
    input  logic [YW-1:0]        cy,
    input  logic signed [EW-1:0] err,
    input  logic signed [EW-1:0] dxa,
    input  logic signed [EW-1:0] dya,
    input  logic                 sx_neg,
    input  logic                 sy_neg,
    output logic [XW-1:0]        nx,
    output logic [YW-1:0]        ny,
    output logic signed [EW-1:0] nerr
);
    localparam logic [XW-1:0] ONE_X = XW'(1);
    localparam logic [YW-1:0] ONE_Y = YW'(1);

    logic signed [EW:0] e2, dxe, dye;
    logic step_x, step_y;

    always_comb begin
        e2     = $signed({err, 1'b0});
        dxe    = $signed({dxa[EW-1], dxa});
        dye    = $signed({dya[EW-1], dya});
        step_x = (e2 >= -dye);
        step_y = (e2 <= dxe);
        nerr   = err - (step_x ? dya : '0) + (step_y ? dxa : '0);
        nx     = step_x ? (sx_neg ? cx - ONE_X : cx + ONE_X) : cx;
        ny     = step_y ? (sy_neg ? cy - ONE_Y : cy + ONE_Y) : cy;
    end
endmodule

// File: rtl/gfx_rect_step.sv
module gfx_rect_step #(
    parameter int XW = 11,
    parameter int YW = 11
) (
    input  logic [XW-1:0] cx,
    input  logic [YW-1:0] cy,
    input  logic [XW-1:0] x0,
    input  logic [XW-1:0] xlen,
    input  logic [YW-1:0] y0,
    input  logic [YW-1:0] ylen,
    output logic [XW-1:0] nx,
    output logic [YW-1:0] ny,
    output logic          last
);
    localparam logic [XW-1:0] ONE_X = XW'(1);
    localparam logic [YW-1:0] ONE_Y = YW'(1);

    logic row_end;

    always_comb begin
        row_end = (cx == x0 + xlen);
        last    = row_end && (cy == y0 + ylen);
        nx      = row_end ? x0 : cx + ONE_X;
        ny      = row_end ? cy + ONE_Y : cy;
    end
endmodule

// File: rtl/gfx_engine.sv
module gfx_engine
    import gfx_pkg::*;
#(
    parameter int SCR_W = 1920,
    parameter int SCR_H = 1080,
    parameter int AW    = $clog2(SCR_W * SCR_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic          ready,
    output logic [15:0]   rd_color,
    output logic          fb_we,
    output logic          fb_re,
    output logic [AW-1:0] fb_addr,
    output logic [15:0]   fb_wdata,
    input  logic [15:0]   fb_rdata
);
    localparam int XW = $clog2(SCR_W);
    localparam int YW = $clog2(SCR_H);
    localparam int EW = ((XW > YW) ? XW : YW) + 3;

    typedef struct packed {
        state_e            st;
        logic [15:0]       color;
        logic [XW-1:0]     lx0, lx1, flx, fx, px, rx, cx, ex;
        logic [YW-1:0]     ly0, ly1, fly, fy, py, ry, cy, ey;
        logic signed [EW-1:0] dxa, dya, err;
        logic              sx_neg, sy_neg;
        logic [15:0]       rdc;
    } regs_t;

    regs_t q, n;

    logic [XW-1:0]        ln_x, rc_x, wx;
    logic [YW-1:0]        ln_y, rc_y, wy;
    logic signed [EW-1:0] ln_err;
    logic                 rc_last;
    logic [XW-1:0]        adx;
    logic [YW-1:0]        ady;

    gfx_line_step #(.XW(XW), .YW(YW), .EW(EW)) u_line (
        .cx(q.cx), .cy(q.cy), .err(q.err), .dxa(q.dxa), .dya(q.dya),
        .sx_neg(q.sx_neg), .sy_neg(q.sy_neg),
        .nx(ln_x), .ny(ln_y), .nerr(ln_err)
    );

    gfx_rect_step #(.XW(XW), .YW(YW)) u_rect (
        .cx(q.cx), .cy(q.cy), .x0(q.fx), .xlen(q.flx), .y0(q.fy), .ylen(q.fly),
        .nx(rc_x), .ny(rc_y), .last(rc_last)
    );

    always_comb begin
        n   = q;
        wx  = reg_wdata[XW-1:0];
        wy  = reg_wdata[YW-1:0];
        adx = (q.lx1 >= q.lx0) ? q.lx1 - q.lx0 : q.lx0 - q.lx1;
        ady = (wy >= q.ly0) ? wy - q.ly0 : q.ly0 - wy;
        case (q.st)
            S_IDLE: begin
                if (reg_we) begin
                    case (reg_addr)
                        A_COLOR: n.color = reg_wdata;
                        A_LX0:   n.lx0 = wx;
                        A_LY0:   n.ly0 = wy;
                        A_LX1:   n.lx1 = wx;
                        A_LY1: begin
                            n.ly1    = wy;
                            n.cx     = q.lx0;
                            n.cy     = q.ly0;
                            n.ex     = q.lx1;
                            n.ey     = wy;
                            n.dxa    = EW'(adx);
                            n.dya    = EW'(ady);
                            n.err    = EW'(adx) - EW'(ady);
                            n.sx_neg = (q.lx1 < q.lx0);
                            n.sy_neg = (wy < q.ly0);
                            n.st     = S_LINE;
                        end
                        A_FLX:   n.flx = wx;
                        A_FLY:   n.fly = wy;
                        A_FX:    n.fx  = wx;
                        A_FY: begin
                            n.fy = wy;
                            n.cx = q.fx;
                            n.cy = wy;
                            n.st = S_FILL;
                        end
                        A_PX:    n.px = wx;
                        A_PY: begin
                            n.py = wy;
                            n.cx = q.px;
                            n.cy = wy;
                            n.st = S_PLOT;
                        end
                        A_RX:    n.rx = wx;
                        A_RY: begin
                            n.ry = wy;
                            n.cx = q.rx;
                            n.cy = wy;
                            n.st = S_RDREQ;
                        end
                        default: ;
                    endcase
                end
            end
            S_LINE: begin
                if (q.cx == q.ex && q.cy == q.ey) begin
                    n.st = S_IDLE;
                end else begin
                    n.cx  = ln_x;
                    n.cy  = ln_y;
                    n.err = ln_err;
                end
            end
            S_FILL: begin
                n.cx = rc_x;
                n.cy = rc_y;
                if (rc_last) n.st = S_IDLE;
            end
            S_PLOT:   n.st = S_IDLE;
            S_RDREQ:  n.st = S_RDWAIT;
            S_RDWAIT: begin
                n.rdc = fb_rdata;
                n.st  = S_IDLE;
            end
            default:  n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign ready    = (q.st == S_IDLE);
    assign rd_color = q.rdc;
    assign fb_we    = (q.st == S_LINE) || (q.st == S_FILL) || (q.st == S_PLOT);
    assign fb_re    = (q.st == S_RDREQ);
    assign fb_wdata = q.color;
    assign fb_addr  = AW'(q.cy) * AW'(SCR_W) + AW'(q.cx);

    // R7: the memory port is used only while the processor is stalled
    p_port_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we || fb_re) |-> !ready);

    // R7: an accepted launching write stalls the processor on the next cycle
    p_trigger_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && reg_we && (reg_addr == A_LY1 || reg_addr == A_FY ||
                             reg_addr == A_PY || reg_addr == A_RY)) |=> !ready);

    // R8: writes during a command leave the parameters untouched
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && reg_we) |=> ($stable(q.color) && $stable(q.lx0) && $stable(q.fx)));

    // R4: inside a row the fill cursor advances by exactly one pixel
    p_fill_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_FILL && q.cx != q.fx + q.flx) |=> (q.cx == $past(q.cx) + XW'(1)));

    // R6: a read request is followed by a stall cycle, then release
    p_read_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fb_re |=> (!ready && !fb_re && !fb_we));

    // R2: the write data never changes during a command
    p_color_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we && $past(fb_we)) |-> $stable(fb_wdata));
endmodule

// File: tb/gfx_engine_tb.sv
module gfx_engine_tb;
    localparam int W  = 32;
    localparam int H  = 24;
    localparam int AW = $clog2(W * H);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic          ready;
    logic [15:0]   rd_color;
    logic          fb_we, fb_re;
    logic [AW-1:0] fb_addr;
    logic [15:0]   fb_wdata;
    logic [15:0]   fb_rdata = '0;

    logic [15:0] mem [W*H];
    logic [15:0] expm [W*H];

    int  n_chk = 0;
    int  n_fail = 0;
    int  port_misuse = 0;
    bit  done = 1'b0;
    int  cur_color = 0;

    always #5 clk = ~clk;

    gfx_engine #(.SCR_W(W), .SCR_H(H)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ready(ready), .rd_color(rd_color),
        .fb_we(fb_we), .fb_re(fb_re), .fb_addr(fb_addr),
        .fb_wdata(fb_wdata), .fb_rdata(fb_rdata)
    );

    always @(posedge clk) begin
        if (fb_we && int'(fb_addr) < W*H) mem[fb_addr] <= fb_wdata;
        if (fb_re && int'(fb_addr) < W*H) fb_rdata <= mem[fb_addr];
    end

    always @(negedge clk) begin
        if (rst_n && ready && (fb_we || fb_re)) port_misuse++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        reg_we    = 1'b1;
        reg_addr  = 4'(a);
        reg_wdata = 16'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle(output int busy);
        busy = 0;
        while (!ready && busy < 5000) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        for (int i = 0; i < W*H; i++) if (mem[i] !== expm[i]) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic ref_line(input int x0, input int y0, input int x1, input int y1);
        int x = x0, y = y0, dx = iabs(x1 - x0), dy = -iabs(y1 - y0);
        int sx = (x1 >= x0) ? 1 : -1, sy = (y1 >= y0) ? 1 : -1;
        int err = dx + dy, e2;
        for (int k = 0; k < 4096; k++) begin
            expm[y*W + x] = 16'(cur_color);
            if (x == x1 && y == y1) break;
            e2 = 2 * err;
            if (e2 >= dy) begin err += dy; x += sx; end
            if (e2 <= dx) begin err += dx; y += sy; end
        end
    endtask

    task automatic do_line(input int x0, input int y0, input int x1, input int y1);
        int busy, exp_b;
        wr(1, x0); wr(2, y0); wr(3, x1); wr(4, y1);
        wait_idle(busy);
        ref_line(x0, y0, x1, y1);
        exp_b = ((iabs(x1-x0) > iabs(y1-y0)) ? iabs(x1-x0) : iabs(y1-y0)) + 1;
        check(busy == exp_b, "R10 line cycles", busy, exp_b);
        cmp_mem("R3 line pixels");
    endtask

    task automatic do_fill(input int x, input int y, input int lw, input int lh);
        int busy;
        wr(5, lw); wr(6, lh); wr(7, x); wr(8, y);
        wait_idle(busy);
        for (int j = y; j <= y + lh; j++)
            for (int i = x; i <= x + lw; i++) expm[j*W + i] = 16'(cur_color);
        check(busy == (lw+1)*(lh+1), "R10 fill cycles", busy, (lw+1)*(lh+1));
        cmp_mem("R4 fill pixels");
    endtask

    task automatic do_plot(input int x, input int y);
        int busy;
        wr(9, x); wr(10, y);
        wait_idle(busy);
        expm[y*W + x] = 16'(cur_color);
        check(busy == 1, "R5 plot cycles", busy, 1);
        cmp_mem("R9 plot address");
    endtask

    task automatic do_read(input int x, input int y);
        int busy;
        wr(11, x); wr(12, y);
        wait_idle(busy);
        check(busy == 2, "R10 read cycles", busy, 2);
        check(rd_color === expm[y*W + x], "R6 read colour", int'(rd_color), int'(expm[y*W + x]));
    endtask

    task automatic set_color(input int c);
        wr(0, c);
        cur_color = c;
    endtask

    initial begin
        for (int i = 0; i < W*H; i++) begin mem[i] = '0; expm[i] = '0; end
        repeat (3) @(negedge clk);
        check(ready == 1'b1, "R1 ready", int'(ready), 1);
        check(fb_we == 1'b0 && fb_re == 1'b0, "R1 port idle", int'(fb_we | fb_re), 0);
        check(rd_color == 16'h0, "R1 rd_color", int'(rd_color), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 5-6-5 colours, R9 corners
        set_color(16'hF800);
        do_plot(0, 0);
        do_plot(W-1, H-1);
        set_color(16'h07E0);
        do_fill(0, 0, W-1, H-1);
        cmp_mem("R2 fill colour");
        do_read(W-1, H-1);

        // R3 all octants from centre, plus a single-point line
        set_color(16'h001F);
        do_line(16, 12, 31, 15);
        do_line(16, 12, 20, 23);
        do_line(16, 12, 12, 23);
        do_line(16, 12, 0, 16);
        do_line(16, 12, 0, 8);
        do_line(16, 12, 13, 0);
        do_line(16, 12, 19, 0);
        do_line(16, 12, 31, 9);
        do_line(5, 5, 5, 5);
        do_line(2, 20, 29, 20);
        do_read(16, 12);

        // R8 writes during a running fill are dropped
        begin
            int busy;
            set_color(16'hAAAA);
            wr(9, 7);
            wr(5, 9); wr(6, 4); wr(7, 3); wr(8, 2);
            wr(0, 16'h1234);
            wr(1, 0); wr(2, 0); wr(3, 31); wr(4, 23);
            wr(9, 30);
            wait_idle(busy);
            for (int j = 2; j <= 6; j++)
                for (int i = 3; i <= 12; i++) expm[j*W + i] = 16'hAAAA;
            cmp_mem("R8 no line drawn");
            wr(10, 20);
            wait_idle(busy);
            expm[20*W + 7] = 16'hAAAA;
            check(mem[20*W + 7] === 16'hAAAA, "R8 colour kept", int'(mem[20*W + 7]), 16'hAAAA);
            cmp_mem("R8 plot X kept");
        end

        // random mix
        begin
            int unsigned seed = $urandom(32'd4242);
            for (int it = 0; it < 40; it++) begin
                int cmd = int'($urandom_range(3, 0));
                set_color(int'($urandom_range(16'hFFFF, 0)));
                case (cmd)
                    0: do_line(int'($urandom_range(W-1, 0)), int'($urandom_range(H-1, 0)),
                               int'($urandom_range(W-1, 0)), int'($urandom_range(H-1, 0)));
                    1: begin
                        int fx = int'($urandom_range(W-1, 0));
                        int fy = int'($urandom_range(H-1, 0));
                        do_fill(fx, fy, int'($urandom_range(W-1-fx, 0)),
                                int'($urandom_range(H-1-fy, 0)));
                    end
                    2: do_plot(int'($urandom_range(W-1, 0)), int'($urandom_range(H-1, 0)));
                    default: do_read(int'($urandom_range(W-1, 0)), int'($urandom_range(H-1, 0)));
                endcase
            end
            if (seed == 32'hFFFF_FFFF) $display("seed wrap");
        end

        check(port_misuse == 0, "R7 port while ready", port_misuse, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule